// File: doc/BRIEF.md
# Serial Flash Write-Protection Guard

This block decides whether a decoded flash command may take effect. It holds the protection state of a serial flash device: a write-enable latch, a two-bit protected-zone field and a lock bit that freezes the status fields. Upstream logic shifts and decodes the commands. Each command arrives as a one-cycle strobe with an opcode, a target address and, for status writes, a new status value. The block answers each command with a one-cycle grant or deny pulse. It also reports its protection mode at all times.

The protection mode is kept in a three-state machine. OPEN applies while the lock bit is clear. SOFT applies while the lock bit is set and the active-low protect pin is high. HARD applies while the lock bit is set and the pin is low. The transitions are as follows:
- OPEN goes to SOFT (ARM_SOFT) or to HARD (ARM_HARD) when a status write sets the lock bit, depending on the pin.
- SOFT goes to HARD (PIN_DROP) when the synchronized pin falls.
- HARD returns to SOFT (PIN_RISE) only when the pin rises.
- SOFT or HARD goes back to OPEN (UNLOCK) when the lock bit is cleared.

In HARD, status writes are refused, so the lock bit cannot be cleared from that state. HARD is reached in either order: the lock is set while the pin is low, or the pin falls while the lock is set.

Top module: `wp_guard`

## Requirements
- R1: After reset, the latch, the lock bit and the zone field are 0, the mode is OPEN (code 0), and neither grant nor deny is high.
- R2: A write-enable command (opcode 1) is always granted and sets the latch. A write-disable command (opcode 2) is always granted and clears the latch.
- R3: A status write (opcode 3, new value bit 2 = lock, bits 1:0 = zone) is denied while the latch is clear. A denied command changes neither the latch nor the status fields.
- R4: While the lock bit is 0, a status write with the latch set is granted at either pin level. It loads the lock bit and the zone field and clears the latch.
- R5: With the lock bit set and the pin high, the mode is SOFT (code 1), and a status write with the latch set is granted.
- R6: With the lock bit set and the pin low, the mode is HARD (code 2). A status write is then denied even with the latch set, and the lock bit and the zone field keep their values.
- R7: HARD is reached by setting the lock bit while the pin is low, and also by dropping the pin after the lock bit is set. It is left for SOFT only by raising the pin.
- R8: The zone field selects the protected addresses: 0 selects none, 1 the top quarter, 2 the top half and 3 all. A page program (opcode 4) or sector erase (opcode 5) inside the zone is denied. Outside the zone it is granted when the latch is set.
- R9: A bulk erase (opcode 6) is denied whenever the zone field is non-zero. It is granted when the zone field is 0 and the latch is set.
- R10: A program or erase command is denied while the latch is clear.
- R11: A granted program, sector erase or bulk erase clears the latch.
- R12: Each valid command with opcode 1 to 6 gives exactly one one-cycle pulse, grant or deny, in the cycle after the strobe. Opcodes 0 and 7 give neither pulse. A pin change reaches the mode output after SYNC_STAGES+1 rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | ADDR_W | Target address of a program or erase |
| cmd_sr | input | 3 | New status value: bit 2 lock, bits 1:0 zone |
| wp_n | input | 1 | Active-low write-protect pin, asynchronous |
| grant_o | output | 1 | Command accepted pulse |
| deny_o | output | 1 | Command rejected pulse |
| prot_mode_o | output | 2 | Mode: 0 OPEN, 1 SOFT, 2 HARD |
| wel_o | output | 1 | Write-enable latch |
| lock_o | output | 1 | Status lock bit |
| zone_o | output | 2 | Protected-zone field |

## Verification
The assertions assume three things about the inputs. Command strobes are single cycles with a known opcode. The opcode and address are stable in the strobe cycle. The protect pin is held long enough for the synchronizer and the mode register to settle before a status write is judged. The stimulus meets these conditions in three ways. It drives every input on the falling edge. It raises the strobe for exactly one cycle. It waits four cycles after each pin change before the next command. The one test that checks the pin-to-mode latency edge by edge issues no command during that window.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_WREN = 3'd1,
        OP_WRDI = 3'd2,
        OP_WRSR = 3'd3,
        OP_PROG = 3'd4,
        OP_SECT = 3'd5,
        OP_BULK = 3'd6,
        OP_RSVD = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        MODE_OPEN = 2'd0,
        MODE_SOFT = 2'd1,
        MODE_HARD = 2'd2
    } mode_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] zone;
    } sr_t;

endpackage

// File: rtl/wp_pin_sync.sv
module wp_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pin_o
);
    generate
        if (STAGES <= 1) begin : g_single
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= 1'b1;
                else        q <= pin_i;
            end
            assign pin_o = q;
        end else begin : g_chain
            logic [STAGES-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '1;
                else        q <= {q[STAGES-2:0], pin_i};
            end
            assign pin_o = q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/wp_region_chk.sv
module wp_region_chk #(
    parameter int ADDR_W = 24
) (
    input  logic [1:0]        zone_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              in_zone_o
);
    localparam logic [ADDR_W-1:0] HALF_BASE = {1'b1, {(ADDR_W-1){1'b0}}};
    localparam logic [ADDR_W-1:0] QTR_BASE  = {2'b11, {(ADDR_W-2){1'b0}}};

    always_comb begin
        unique case (zone_i)
            2'b00:   in_zone_o = 1'b0;
            2'b01:   in_zone_o = (addr_i >= QTR_BASE);
            2'b10:   in_zone_o = (addr_i >= HALF_BASE);
            default: in_zone_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wp_cmd_judge.sv
module wp_cmd_judge
    import wp_pkg::*;
(
    input  logic       valid_i,
    input  op_e        op_i,
    input  logic       wel_i,
    input  mode_e      mode_i,
    input  logic       in_zone_i,
    input  logic [1:0] zone_i,
    output logic       grant_o,
    output logic       deny_o
);
    logic ok;
    logic known;

    always_comb begin
        ok    = 1'b0;
        known = 1'b1;
        unique case (op_i)
            OP_WREN: ok = 1'b1;
            OP_WRDI: ok = 1'b1;
            OP_WRSR: ok = wel_i && (mode_i != MODE_HARD);
            OP_PROG: ok = wel_i && !in_zone_i;
            OP_SECT: ok = wel_i && !in_zone_i;
            OP_BULK: ok = wel_i && (zone_i == 2'b00);
            default: known = 1'b0;
        endcase
    end

    assign grant_o = valid_i && known && ok;
    assign deny_o  = valid_i && known && !ok;
endmodule

// File: rtl/wp_mode_fsm.sv
module wp_mode_fsm
    import wp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lock_i,
    input  logic  pin_hi_i,
    output mode_e mode_o
);
    mode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_OPEN: begin
                if (lock_i) state_d = pin_hi_i ? MODE_SOFT : MODE_HARD; // ARM_SOFT / ARM_HARD
            end
            MODE_SOFT: begin
                if (!lock_i)       state_d = MODE_OPEN;                 // UNLOCK
                else if (!pin_hi_i) state_d = MODE_HARD;                // PIN_DROP
            end
            MODE_HARD: begin
                if (!lock_i)      state_d = MODE_OPEN;                  // UNLOCK
                else if (pin_hi_i) state_d = MODE_SOFT;                 // PIN_RISE
            end
            default: state_d = MODE_OPEN;
        endcase
    end

    always_comb begin
        mode_o = state_q;
    end

    // R7
    hard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_HARD && !pin_hi_i && lock_i) |=> state_q == MODE_HARD);
endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [2:0]        cmd_sr,
    input  logic              wp_n,
    output logic              grant_o,
    output logic              deny_o,
    output logic [1:0]        prot_mode_o,
    output logic              wel_o,
    output logic              lock_o,
    output logic [1:0]        zone_o
);
    op_e   op;
    logic  pin_hi;
    logic  in_zone;
    logic  grant, deny;
    logic  wel_q, wel_d;
    sr_t   sr_q, sr_d;
    mode_e mode;
    logic  grant_q, deny_q;

    assign op = op_e'(cmd_op);

    wp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (wp_n),
        .pin_o (pin_hi)
    );

    wp_region_chk #(.ADDR_W(ADDR_W)) u_zone (
        .zone_i    (sr_q.zone),
        .addr_i    (cmd_addr),
        .in_zone_o (in_zone)
    );

    wp_cmd_judge u_judge (
        .valid_i   (cmd_valid),
        .op_i      (op),
        .wel_i     (wel_q),
        .mode_i    (mode),
        .in_zone_i (in_zone),
        .zone_i    (sr_q.zone),
        .grant_o   (grant),
        .deny_o    (deny)
    );

    always_comb begin
        wel_d = wel_q;
        sr_d  = sr_q;
        if (grant) begin
            unique case (op)
                OP_WREN: wel_d = 1'b1;
                OP_WRSR: begin
                    wel_d = 1'b0;
                    sr_d  = sr_t'(cmd_sr);
                end
                default: wel_d = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q   <= 1'b0;
            sr_q    <= '0;
            grant_q <= 1'b0;
            deny_q  <= 1'b0;
        end else begin
            wel_q   <= wel_d;
            sr_q    <= sr_d;
            grant_q <= grant;
            deny_q  <= deny;
        end
    end

    wp_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_i   (sr_d.lock),
        .pin_hi_i (pin_hi),
        .mode_o   (mode)
    );

    assign grant_o     = grant_q;
    assign deny_o      = deny_q;
    assign prot_mode_o = mode;
    assign wel_o       = wel_q;
    assign lock_o      = sr_q.lock;
    assign zone_o      = sr_q.zone;

    // R12
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && deny_o));

    // R3
    deny_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deny_o |-> ($stable(wel_q) && $stable(sr_q)));

    // R6
    hard_blocks_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd3 && mode == MODE_HARD) |=> (deny_o && $stable(sr_q)));

    // R9
    bulk_zone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd6 && sr_q.zone != 2'b00) |=> deny_o);

    // R2
    wren_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1) |=> (grant_o && wel_q));

    // R11
    wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'd4 || cmd_op == 3'd5 || cmd_op == 3'd6)) |=> (!grant_o || !wel_q));
endmodule

// File: tb/sim_wp_guard.sv
`timescale 1ns/1ps
module sim_wp_guard;
    localparam int AW   = 24;
    localparam int SYNC = 2;
    localparam int NV   = 29;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [2:0]    cmd_sr = 3'd0;
    logic          wp_n = 1'b1;
    logic          grant_o, deny_o, wel_o, lock_o;
    logic [1:0]    prot_mode_o, zone_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    wp_guard #(.ADDR_W(AW), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_sr(cmd_sr), .wp_n(wp_n),
        .grant_o(grant_o), .deny_o(deny_o), .prot_mode_o(prot_mode_o),
        .wel_o(wel_o), .lock_o(lock_o), .zone_o(zone_o)
    );

    // fields: op, addr top bits, new status, pin, grant, wel, lock, zone, mode, requirement
    function automatic logic [19:0] mk(int op, int a2, int sr, int pin, int acc,
                                       int wel, int lk, int zn, int md, int rq);
        return {op[2:0], a2[1:0], sr[2:0], pin[0], acc[0], wel[0], lk[0], zn[1:0], md[1:0], rq[3:0]};
    endfunction

    localparam logic [19:0] VEC [NV] = '{
        mk(3,0,1,1, 0,0,0,0,0, 3),  // R3 status write without latch
        mk(4,0,0,1, 0,0,0,0,0, 10), // R10 program without latch
        mk(1,0,0,1, 1,1,0,0,0, 2),  // R2
        mk(2,0,0,1, 1,0,0,0,0, 2),  // R2 write disable
        mk(1,0,0,1, 1,1,0,0,0, 2),
        mk(4,3,0,1, 1,0,0,0,0, 11), // R11 program clears latch
        mk(1,0,0,0, 1,1,0,0,0, 4),
        mk(3,0,1,0, 1,0,0,1,0, 4),  // R4 pin low, lock clear
        mk(1,0,0,0, 1,1,0,1,0, 2),
        mk(4,3,0,0, 0,1,0,1,0, 8),  // R8 top quarter protected
        mk(5,2,0,0, 1,0,0,1,0, 8),  // R8 outside quarter
        mk(1,0,0,0, 1,1,0,1,0, 2),
        mk(6,0,0,0, 0,1,0,1,0, 9),  // R9 bulk with zone set
        mk(3,0,6,0, 1,0,1,2,2, 7),  // R7 lock set while pin low
        mk(1,0,0,0, 1,1,1,2,2, 2),
        mk(3,0,0,0, 0,1,1,2,2, 6),  // R6 hard mode blocks
        mk(5,2,0,0, 0,1,1,2,2, 8),  // R8 top half protected
        mk(5,1,0,0, 1,0,1,2,2, 8),  // R8 lower half open
        mk(1,0,0,1, 1,1,1,2,1, 7),  // R7 pin rise leaves hard
        mk(3,0,7,1, 1,0,1,3,1, 5),  // R5 soft mode write
        mk(1,0,0,1, 1,1,1,3,1, 2),
        mk(4,0,0,1, 0,1,1,3,1, 8),  // R8 whole array
        mk(1,0,0,0, 1,1,1,3,2, 7),  // R7 pin drop after lock
        mk(3,0,0,0, 0,1,1,3,2, 6),  // R6
        mk(1,0,0,1, 1,1,1,3,1, 7),
        mk(3,0,0,1, 1,0,0,0,0, 5),  // R5 unlock from soft
        mk(1,0,0,1, 1,1,0,0,0, 2),
        mk(6,0,0,1, 1,0,0,0,0, 9),  // R9 bulk granted
        mk(6,0,0,1, 0,0,0,0,0, 10)  // R10 bulk without latch
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [AW-1:0] addr, input logic [2:0] sr);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = addr;
        cmd_sr    = sr;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 wel", wel_o, 0);
        check("R1 lock", lock_o, 0);
        check("R1 zone", zone_o, 0);
        check("R1 mode", prot_mode_o, 0);
        check("R1 pulses", {grant_o, deny_o}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d step %0d", v[3:0], i);
            @(negedge clk);
            wp_n = v[11];
            repeat (4) @(negedge clk);
            issue(v[19:17], {v[16:15], 22'h012345}, v[14:12]);
            check({tag, " grant"}, grant_o, v[10]);
            check({tag, " deny"}, deny_o, !v[10]);
            check({tag, " wel"}, wel_o, v[9]);
            check({tag, " lock"}, lock_o, v[8]);
            check({tag, " zone"}, zone_o, v[7:6]);
            check({tag, " mode"}, prot_mode_o, v[5:4]);
        end

        // R12 pin-to-mode latency: set lock with pin high, then drop pin
        issue(3'd1, '0, 3'd0);
        issue(3'd3, '0, 3'b100);
        check("R5 soft after lock", prot_mode_o, 1);
        wp_n = 1'b0;
        repeat (SYNC) @(negedge clk);
        check("R12 mode before latency", prot_mode_o, 1);
        @(negedge clk);
        check("R12 mode after latency", prot_mode_o, 2);

        // R12 reserved opcodes give no pulse
        issue(3'd7, '0, 3'd0);
        check("R12 op7 pulses", {grant_o, deny_o}, 0);
        issue(3'd0, '0, 3'd0);
        check("R12 op0 pulses", {grant_o, deny_o}, 0);
        check("R12 op0 wel", wel_o, 0);

        // R1 reset in the middle of hard mode
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 lock after reset", lock_o, 0);
        check("R1 mode after reset", prot_mode_o, 0);
        check("R1 wel after reset", wel_o, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule